// File: doc/BRIEF.md
# Parallel Video Output Link Formatter

This block sits between a test-pattern source and the parallel video output of a display driver. It takes one pixel per dot clock. The pixel is LSB-aligned in its input bus, and a programmable pattern bit length gives its real width. The block also takes horizontal and vertical sync, composite sync and the display-enable strobe. It places the pixel on two 10-bit output channels and adapts the width by dropping low-order bits or appending zeros.

The block has four link modes. The first sends one 8-bit link and copies it onto both channels. The second is a dual 8-bit link, where consecutive pixels are paired across the two channels. The third is a single 16-bit link split across both channels. The fourth picks a 10-bit or a 16-bit single link from the pattern bit length. Every sync output has its own polarity select, and so does the forwarded dot clock. A registered flag reports a dot-clock frequency code or a pattern bit length that is not legal for the current mode.

Top module: `vlf_link_fmt`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ch1_o`, `ch2_o`, `hd_o`, `vd_o`, `cs_o`, `disp_o` and `cfg_err_o` are all zero after that edge.
- R2: Only bits below `pat_len` of `pix_i` count as the pixel, and higher bits are ignored. A pixel wider than the target length keeps its most significant bits. A narrower pixel gets zeros appended below its LSB.
- R3: Link mode 0 (`link_mode_i` = 2'b00) puts the pixel fitted to 8 bits in `ch1_o[9:2]` with `ch1_o[1:0]` = 0. `ch2_o` equals `ch1_o`. The result shows one clock after the pixel is presented.
- R4: Link mode 1 (2'b01) pairs pixels. An even pixel is held. On the following odd pixel, both fitted to 8 bits appear one clock later: the even one in `ch1_o[9:2]` and the odd one in `ch2_o[9:2]`, with both low bit pairs zero. The channels keep their value through the clock after an even pixel.
- R5: In link mode 1, a pixel presented in a cycle where `hd_i` is high and was low in the previous cycle is always treated as even, whatever the pairing state was.
- R6: Link mode 2 (2'b10) fits the pixel to 16 bits. Bits [15:8] go to `ch1_o[9:2]` and bits [7:0] go to `ch2_o[9:2]`, with low bit pairs zero and one clock of latency.
- R7: Link mode 3 (2'b11) selects 10-bit output when `pat_len` ≤ 10. In that case `ch1_o` is the pixel fitted to 10 bits and `ch2_o` equals `ch1_o`. For a longer pixel it behaves as link mode 2.
- R8: For each of HD, VD, CS and DISP, a polarity select of 1 passes the input to the output unchanged, and 0 passes it inverted, one clock later. `clk_o` equals `clk` when `pol_clk_i` is 1 and its inverse when 0, with no register.
- R9: Outside link mode 1, a sync transition and the pixel presented in the same cycle appear at the outputs on the same clock edge.
- R10: `freq_code_i` gives the dot clock in units of 100 kHz. `cfg_err_o` goes to 1 one clock after a cycle where the code lies outside 1..1000 in modes 0, 2 and 3, or outside 2..2000 in mode 1, or where `pat_len` is 0 or above 16. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_mode_i | input | 2 | Link mode select |
| pat_len | input | 5 | Pattern gray-scale bit length, 1..16 |
| freq_code_i | input | 11 | Dot clock frequency, 100 kHz units |
| pix_i | input | 16 | Pixel, LSB-aligned |
| hd_i | input | 1 | Horizontal sync in |
| vd_i | input | 1 | Vertical sync in |
| cs_i | input | 1 | Composite sync in |
| disp_i | input | 1 | Display enable in |
| pol_clk_i | input | 1 | Clock polarity, 1 = unchanged |
| pol_hd_i | input | 1 | HD polarity, 1 = unchanged |
| pol_vd_i | input | 1 | VD polarity, 1 = unchanged |
| pol_cs_i | input | 1 | CS polarity, 1 = unchanged |
| pol_disp_i | input | 1 | DISP polarity, 1 = unchanged |
| ch1_o | output | 10 | Output channel 1 |
| ch2_o | output | 10 | Output channel 2 |
| hd_o | output | 1 | Horizontal sync out |
| vd_o | output | 1 | Vertical sync out |
| cs_o | output | 1 | Composite sync out |
| disp_o | output | 1 | Display enable out |
| clk_o | output | 1 | Forwarded dot clock |
| cfg_err_o | output | 1 | Configuration error flag |

## Verification
In dual mode, the HD rising edge that restarts pixel pairing can arrive in the same cycle as a pixel that the running toggle would treat as odd. The bench provokes this with a line break placed mid-pair: it presents one pixel with HD low, then raises HD together with the next pixel. The check passes if the channels keep the previous pair for that cycle and then show the two pixels that follow the edge, not a pair that straddles it.

// File: rtl/vlf_pkg.sv
// Shared types for the parallel video link formatter.
package vlf_pkg;
    typedef enum logic [1:0] {
        LM_SINGLE8  = 2'b00,
        LM_DUAL8    = 2'b01,
        LM_SINGLE16 = 2'b10,
        LM_AUTO     = 2'b11
    } link_mode_e;
endpackage

// File: rtl/vlf_width_fit.sv
// Width fitter: masks the pixel to its pattern length and shifts it so its MSB
// sits at bit PIX_W-1. Any narrower target is then a top slice of norm_o, which
// drops excess LSBs or leaves zeros below. Assumes pat_len <= PIX_W is legal;
// larger values are clamped to PIX_W.
module vlf_width_fit #(
    parameter int PIX_W = 16,
    parameter int LEN_W = $clog2(PIX_W + 1)
) (
    input  logic [PIX_W-1:0] pix_i,
    input  logic [LEN_W-1:0] pat_len,
    output logic [PIX_W-1:0] norm_o
);
    logic [LEN_W-1:0] len_c;
    logic [PIX_W-1:0] masked;

    // Clamp the length, mask unused upper bits, then MSB-align.
    always_comb begin
        len_c = (pat_len > LEN_W'(PIX_W)) ? LEN_W'(PIX_W) : pat_len;
        for (int i = 0; i < PIX_W; i++) begin
            masked[i] = pix_i[i] & (LEN_W'(i) < len_c);
        end
        norm_o = masked << (LEN_W'(PIX_W) - len_c);
    end
endmodule

// File: rtl/vlf_lane_map.sv
// Lane mapper: builds the two channel words for the single-link modes and the
// 8-bit lane word used by dual mode. Assumes CH_W >= 8 and PIX_W >= 16.
module vlf_lane_map
    import vlf_pkg::*;
#(
    parameter int PIX_W    = 16,
    parameter int CH_W     = 10,
    parameter int LEN_W    = $clog2(PIX_W + 1),
    parameter int AUTO_MAX = 10
) (
    input  logic [PIX_W-1:0] norm_i,
    input  link_mode_e       mode_i,
    input  logic [LEN_W-1:0] pat_len,
    output logic [CH_W-1:0]  lane1_o,
    output logic [CH_W-1:0]  lane2_o,
    output logic [CH_W-1:0]  byte_lane_o
);
    localparam int PAD_W = CH_W - 8;

    logic [CH_W-1:0] hi_lane;
    logic [CH_W-1:0] lo_lane;
    logic [CH_W-1:0] wide_lane;

    // Candidate lane words taken as slices of the normalized pixel.
    always_comb begin
        hi_lane     = {norm_i[PIX_W-1 -: 8], {PAD_W{1'b0}}};
        lo_lane     = {norm_i[PIX_W-9 -: 8], {PAD_W{1'b0}}};
        wide_lane   = norm_i[PIX_W-1 -: CH_W];
        byte_lane_o = hi_lane;
    end

    // Pick the lane words for the active mode.
    always_comb begin
        unique case (mode_i)
            LM_SINGLE8, LM_DUAL8: begin
                lane1_o = hi_lane;
                lane2_o = hi_lane;
            end
            LM_SINGLE16: begin
                lane1_o = hi_lane;
                lane2_o = lo_lane;
            end
            default: begin
                if (pat_len <= LEN_W'(AUTO_MAX)) begin
                    lane1_o = wide_lane;
                    lane2_o = wide_lane;
                end else begin
                    lane1_o = hi_lane;
                    lane2_o = lo_lane;
                end
            end
        endcase
    end
endmodule

// File: rtl/vlf_pair_ctl.sv
// Dual-link pairing: holds the even pixel's lane word and flags the odd pixel
// that completes a pair. An HD rising edge forces the current pixel to be even.
// Assumes hd_rise_i is a one-cycle pulse derived from the raw HD input.
module vlf_pair_ctl #(
    parameter int CH_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dual_en_i,
    input  logic            hd_rise_i,
    input  logic [CH_W-1:0] lane_i,
    output logic            pair_done_o,
    output logic [CH_W-1:0] even_lane_o
);
    logic odd_q;

    assign pair_done_o = dual_en_i && odd_q && !hd_rise_i;

    // Advance the even/odd toggle and capture even pixels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_q       <= 1'b0;
            even_lane_o <= '0;
        end else if (!dual_en_i) begin
            odd_q <= 1'b0;
        end else if (pair_done_o) begin
            odd_q <= 1'b0;
        end else begin
            odd_q       <= 1'b1;
            even_lane_o <= lane_i;
        end
    end
endmodule

// File: rtl/vlf_sync_pol.sv
// Sync polarity stage: applies a per-signal polarity select (1 = unchanged,
// 0 = inverted) and registers each result with one clock of latency.
module vlf_sync_pol #(
    parameter int N_SIG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] sig_i,
    input  logic [N_SIG-1:0] pol_i,
    output logic [N_SIG-1:0] sig_o
);
    for (genvar g = 0; g < N_SIG; g++) begin : g_sig
        // Register one polarity-adjusted sync signal.
        always_ff @(posedge clk) begin
            if (!rst_n) sig_o[g] <= 1'b0;
            else        sig_o[g] <= sig_i[g] ~^ pol_i[g];
        end
    end
endmodule

// File: rtl/vlf_rate_chk.sv
// Configuration check: flags a dot-clock code outside the window for the
// current mode, or an illegal pattern length. Purely combinational.
module vlf_rate_chk
    import vlf_pkg::*;
#(
    parameter int FREQ_W   = 11,
    parameter int LEN_W    = 5,
    parameter int PIX_W    = 16,
    parameter int SGL_MIN  = 1,
    parameter int SGL_MAX  = 1000,
    parameter int DUAL_MIN = 2,
    parameter int DUAL_MAX = 2000
) (
    input  link_mode_e        mode_i,
    input  logic [FREQ_W-1:0] freq_i,
    input  logic [LEN_W-1:0]  pat_len,
    output logic              err_o
);
    logic [FREQ_W-1:0] lo_lim;
    logic [FREQ_W-1:0] hi_lim;

    // Select the frequency window for the mode and compare.
    always_comb begin
        if (mode_i == LM_DUAL8) begin
            lo_lim = FREQ_W'(DUAL_MIN);
            hi_lim = FREQ_W'(DUAL_MAX);
        end else begin
            lo_lim = FREQ_W'(SGL_MIN);
            hi_lim = FREQ_W'(SGL_MAX);
        end
        err_o = (freq_i < lo_lim) || (freq_i > hi_lim) ||
                (pat_len == '0) || (pat_len > LEN_W'(PIX_W));
    end
endmodule

// File: rtl/vlf_link_fmt.sv
// Parallel video link formatter top. Fits each pixel to the link width, maps it
// onto two channels per link mode, applies sync and clock polarity, and
// registers data, sync and error flag with one clock of latency.
// Assumes clk is the dot clock and one pixel is presented per clock.
module vlf_link_fmt
    import vlf_pkg::*;
#(
    parameter int PIX_W  = 16,
    parameter int CH_W   = 10,
    parameter int FREQ_W = 11,
    parameter int LEN_W  = $clog2(PIX_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        link_mode_i,
    input  logic [LEN_W-1:0]  pat_len,
    input  logic [FREQ_W-1:0] freq_code_i,
    input  logic [PIX_W-1:0]  pix_i,
    input  logic              hd_i,
    input  logic              vd_i,
    input  logic              cs_i,
    input  logic              disp_i,
    input  logic              pol_clk_i,
    input  logic              pol_hd_i,
    input  logic              pol_vd_i,
    input  logic              pol_cs_i,
    input  logic              pol_disp_i,
    output logic [CH_W-1:0]   ch1_o,
    output logic [CH_W-1:0]   ch2_o,
    output logic              hd_o,
    output logic              vd_o,
    output logic              cs_o,
    output logic              disp_o,
    output logic              clk_o,
    output logic              cfg_err_o
);
    link_mode_e      mode;
    logic [PIX_W-1:0] norm;
    logic [CH_W-1:0] lane1, lane2, byte_lane, even_lane;
    logic            hd_prev, hd_rise, dual_en, pair_done, err_c;

    assign mode    = link_mode_e'(link_mode_i);
    assign dual_en = (mode == LM_DUAL8);
    assign hd_rise = hd_i && !hd_prev;
    assign clk_o   = pol_clk_i ? clk : ~clk;

    vlf_width_fit #(.PIX_W(PIX_W), .LEN_W(LEN_W)) u_fit (
        .pix_i(pix_i), .pat_len(pat_len), .norm_o(norm)
    );

    vlf_lane_map #(.PIX_W(PIX_W), .CH_W(CH_W), .LEN_W(LEN_W)) u_map (
        .norm_i(norm), .mode_i(mode), .pat_len(pat_len),
        .lane1_o(lane1), .lane2_o(lane2), .byte_lane_o(byte_lane)
    );

    vlf_pair_ctl #(.CH_W(CH_W)) u_pair (
        .clk(clk), .rst_n(rst_n), .dual_en_i(dual_en), .hd_rise_i(hd_rise),
        .lane_i(byte_lane), .pair_done_o(pair_done), .even_lane_o(even_lane)
    );

    vlf_sync_pol #(.N_SIG(4)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sig_i({disp_i, cs_i, vd_i, hd_i}),
        .pol_i({pol_disp_i, pol_cs_i, pol_vd_i, pol_hd_i}),
        .sig_o({disp_o, cs_o, vd_o, hd_o})
    );

    vlf_rate_chk #(.FREQ_W(FREQ_W), .LEN_W(LEN_W), .PIX_W(PIX_W)) u_rate (
        .mode_i(mode), .freq_i(freq_code_i), .pat_len(pat_len), .err_o(err_c)
    );

    // Remember raw HD to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) hd_prev <= 1'b0;
        else        hd_prev <= hd_i;
    end

    // Register channel words; dual mode updates only when a pair completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch1_o <= '0;
            ch2_o <= '0;
        end else if (!dual_en) begin
            ch1_o <= lane1;
            ch2_o <= lane2;
        end else if (pair_done) begin
            ch1_o <= even_lane;
            ch2_o <= byte_lane;
        end
    end

    // Register the configuration error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err_o <= 1'b0;
        else        cfg_err_o <= err_c;
    end
endmodule

// File: rtl/vlf_link_fmt_chk.sv
// Assertion checker for the link formatter, bound to every instance of the top.
module vlf_link_fmt_chk #(
    parameter int PIX_W  = 16,
    parameter int CH_W   = 10,
    parameter int FREQ_W = 11,
    parameter int LEN_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        link_mode_i,
    input logic [LEN_W-1:0]  pat_len,
    input logic [FREQ_W-1:0] freq_code_i,
    input logic [PIX_W-1:0]  pix_i,
    input logic              hd_i,
    input logic              vd_i,
    input logic              cs_i,
    input logic              disp_i,
    input logic              pol_clk_i,
    input logic              pol_hd_i,
    input logic              pol_vd_i,
    input logic              pol_cs_i,
    input logic              pol_disp_i,
    input logic [CH_W-1:0]   ch1_o,
    input logic [CH_W-1:0]   ch2_o,
    input logic              hd_o,
    input logic              vd_o,
    input logic              cs_o,
    input logic              disp_o,
    input logic              clk_o,
    input logic              cfg_err_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (ch1_o == '0 && ch2_o == '0 && !cfg_err_o && !hd_o));

    // R3
    mode0_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(link_mode_i) == 2'b00) |-> (ch2_o == ch1_o));

    // R8
    hd_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (hd_o == ($past(hd_i) ~^ $past(pol_hd_i))));

    // R8
    disp_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (disp_o == ($past(disp_i) ~^ $past(pol_disp_i))));

    // R10
    dual_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(link_mode_i) == 2'b01 &&
         $past(freq_code_i) >= FREQ_W'(2) && $past(freq_code_i) <= FREQ_W'(2000) &&
         $past(pat_len) != '0 && $past(pat_len) <= LEN_W'(PIX_W)) |-> !cfg_err_o);

    // R6
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(link_mode_i) != 2'b11) |->
        (ch1_o[1:0] == 2'b00 && ch2_o[1:0] == 2'b00));
endmodule

bind vlf_link_fmt vlf_link_fmt_chk #(
    .PIX_W(PIX_W), .CH_W(CH_W), .FREQ_W(FREQ_W), .LEN_W(LEN_W)
) u_vlf_chk (.*);

// File: tb/test_vlf_link_fmt.sv
// Directed bench for the link formatter: one task per scenario.
module test_vlf_link_fmt;
    localparam int PIX_W = 16;
    localparam int CH_W  = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  link_mode_i;
    logic [4:0]  pat_len;
    logic [10:0] freq_code_i;
    logic [15:0] pix_i;
    logic        hd_i, vd_i, cs_i, disp_i;
    logic        pol_clk_i, pol_hd_i, pol_vd_i, pol_cs_i, pol_disp_i;
    logic [9:0]  ch1_o, ch2_o;
    logic        hd_o, vd_o, cs_o, disp_o, clk_o, cfg_err_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    vlf_link_fmt i_vlf_link_fmt (
        .clk(clk), .rst_n(rst_n), .link_mode_i(link_mode_i), .pat_len(pat_len),
        .freq_code_i(freq_code_i), .pix_i(pix_i), .hd_i(hd_i), .vd_i(vd_i),
        .cs_i(cs_i), .disp_i(disp_i), .pol_clk_i(pol_clk_i), .pol_hd_i(pol_hd_i),
        .pol_vd_i(pol_vd_i), .pol_cs_i(pol_cs_i), .pol_disp_i(pol_disp_i),
        .ch1_o(ch1_o), .ch2_o(ch2_o), .hd_o(hd_o), .vd_o(vd_o), .cs_o(cs_o),
        .disp_o(disp_o), .clk_o(clk_o), .cfg_err_o(cfg_err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Bit-by-bit fit: output MSB first takes pixel bit len-1 downward, zero past bit 0.
    function automatic logic [15:0] fit(input logic [15:0] p, input int len, input int w);
        logic [15:0] r = '0;
        for (int i = 0; i < w; i++) begin
            int src = len - 1 - i;
            r[w-1-i] = (src >= 0) ? p[src] : 1'b0;
        end
        return r;
    endfunction

    function automatic logic [9:0] byte10(input logic [7:0] b);
        return {b, 2'b00};
    endfunction

    task automatic cycle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; link_mode_i = 2'b00; pat_len = 5'd8; freq_code_i = 11'd500;
        pix_i = 16'hFFFF; hd_i = 1; vd_i = 1; cs_i = 1; disp_i = 1;
        pol_clk_i = 1; pol_hd_i = 1; pol_vd_i = 1; pol_cs_i = 1; pol_disp_i = 1;
        repeat (3) cycle();
        chk("R1 ch1", 32'(ch1_o), 0);
        chk("R1 ch2", 32'(ch2_o), 0);
        chk("R1 sync", {28'b0, hd_o, vd_o, cs_o, disp_o}, 0);
        chk("R1 err", 32'(cfg_err_o), 0);
        rst_n = 1'b1; hd_i = 0; vd_i = 0; cs_i = 0; disp_i = 0;
        cycle();
    endtask

    task automatic t_mode0();
        link_mode_i = 2'b00;
        pat_len = 5'd12; pix_i = 16'h0ABC; cycle();
        chk("R3 trunc ch1", 32'(ch1_o), 32'(byte10(fit(16'h0ABC, 12, 8)[7:0])));
        chk("R3 ch2 copy", 32'(ch2_o), 32'(ch1_o));
        // R2: junk above length ignored, short pixel zero-filled
        pat_len = 5'd4; pix_i = 16'hFFF5; cycle();
        chk("R2 zero fill", 32'(ch1_o), 32'(byte10(8'h50)));
    endtask

    task automatic t_mode2();
        link_mode_i = 2'b10; pat_len = 5'd16; pix_i = 16'h1234; cycle();
        chk("R6 ch1", 32'(ch1_o), 32'(byte10(8'h12)));
        chk("R6 ch2", 32'(ch2_o), 32'(byte10(8'h34)));
        pat_len = 5'd12; pix_i = 16'h0ABC; cycle();
        chk("R6 pad ch2", 32'(ch2_o), 32'(byte10(fit(16'h0ABC, 12, 16)[7:0])));
    endtask

    task automatic t_mode3();
        link_mode_i = 2'b11; pat_len = 5'd10; pix_i = 16'h02A5; cycle();
        chk("R7 10b ch1", 32'(ch1_o), 32'(fit(16'h02A5, 10, 10)));
        chk("R7 10b ch2", 32'(ch2_o), 32'(fit(16'h02A5, 10, 10)));
        pat_len = 5'd6; pix_i = 16'h003F; cycle();
        chk("R7 6b fill", 32'(ch1_o), 32'h3F0);
        pat_len = 5'd14; pix_i = 16'h3ABC; cycle();
        chk("R7 16b ch1", 32'(ch1_o), 32'(byte10(fit(16'h3ABC, 14, 16)[15:8])));
        chk("R7 16b ch2", 32'(ch2_o), 32'(byte10(fit(16'h3ABC, 14, 16)[7:0])));
    endtask

    task automatic t_dual();
        logic [15:0] p [7];
        p = '{16'h0011, 16'h0022, 16'h0033, 16'h0044, 16'h0055, 16'h0066, 16'h0077};
        link_mode_i = 2'b01; pat_len = 5'd8; hd_i = 0; pix_i = 16'h00EE; cycle();
        hd_i = 1; pix_i = p[0]; cycle();
        pix_i = p[1]; cycle();
        chk("R4 pair ch1", 32'(ch1_o), 32'(byte10(p[0][7:0])));
        chk("R4 pair ch2", 32'(ch2_o), 32'(byte10(p[1][7:0])));
        pix_i = p[2]; cycle();
        chk("R4 hold ch1", 32'(ch1_o), 32'(byte10(p[0][7:0])));
        chk("R4 hold ch2", 32'(ch2_o), 32'(byte10(p[1][7:0])));
        pix_i = p[3]; cycle();
        chk("R4 pair2 ch2", 32'(ch2_o), 32'(byte10(p[3][7:0])));
        hd_i = 0; pix_i = p[4]; cycle();
        hd_i = 1; pix_i = p[5]; cycle();
        chk("R5 restart hold", 32'(ch1_o), 32'(byte10(p[2][7:0])));
        pix_i = p[6]; cycle();
        chk("R5 restart ch1", 32'(ch1_o), 32'(byte10(p[5][7:0])));
        chk("R5 restart ch2", 32'(ch2_o), 32'(byte10(p[6][7:0])));
        hd_i = 0;
    endtask

    task automatic t_polarity();
        link_mode_i = 2'b00;
        pol_hd_i = 0; pol_vd_i = 0; pol_cs_i = 0; pol_disp_i = 0; pol_clk_i = 0;
        hd_i = 1; vd_i = 0; cs_i = 1; disp_i = 0; cycle();
        chk("R8 inverted", {28'b0, hd_o, vd_o, cs_o, disp_o}, 32'b0101);
        chk("R8 clk inv", 32'(clk_o), 1);
        pol_hd_i = 1; pol_vd_i = 1; pol_cs_i = 1; pol_disp_i = 1; pol_clk_i = 1;
        vd_i = 1; cycle();
        chk("R8 direct", {28'b0, hd_o, vd_o, cs_o, disp_o}, 32'b1110);
        chk("R8 clk direct", 32'(clk_o), 0);
    endtask

    task automatic t_align();
        link_mode_i = 2'b00; pat_len = 5'd8; hd_i = 0; pix_i = 16'h0000; cycle();
        hd_i = 1; pix_i = 16'h00C3; cycle();
        chk("R9 hd with data", {22'b0, hd_o, ch1_o[9:1]}, {22'b0, 1'b1, 9'(byte10(8'hC3) >> 1)});
        hd_i = 0;
    endtask

    task automatic t_cfg();
        pat_len = 5'd8;
        link_mode_i = 2'b00; freq_code_i = 11'd1000; cycle();
        chk("R10 single max ok", 32'(cfg_err_o), 0);
        freq_code_i = 11'd1001; cycle();
        chk("R10 single over", 32'(cfg_err_o), 1);
        freq_code_i = 11'd0; cycle();
        chk("R10 single zero", 32'(cfg_err_o), 1);
        link_mode_i = 2'b01; freq_code_i = 11'd2000; cycle();
        chk("R10 dual max ok", 32'(cfg_err_o), 0);
        freq_code_i = 11'd1; cycle();
        chk("R10 dual under", 32'(cfg_err_o), 1);
        link_mode_i = 2'b10; freq_code_i = 11'd500; pat_len = 5'd0; cycle();
        chk("R10 len zero", 32'(cfg_err_o), 1);
        pat_len = 5'd17; cycle();
        chk("R10 len over", 32'(cfg_err_o), 1);
        pat_len = 5'd16; cycle();
        chk("R10 len ok", 32'(cfg_err_o), 0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        t_reset();
        t_mode0();
        t_mode2();
        t_mode3();
        t_dual();
        t_polarity();
        t_align();
        t_cfg();
        finish_run();
    end

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end
endmodule